// File: doc/BRIEF.md
# Doubleword Shift Execution Unit

This execute-stage unit performs the 64-bit integer shifts of a load/store processor. There are five of them. Three take their amount from a register operand: logical shift left, logical shift right and arithmetic shift right. The other two take their amount from the instruction: an arithmetic shift right, and an operation that sign-extends the low word and then shifts it left. The decoder outside supplies the extended-opcode field and a form select. It also supplies the source operand and the low bits of the amount register. It also supplies the two immediate shift fields, the record bit and the incoming summary-overflow bit.

The unit is combinational from operands to result. One output register captures the result together with a valid strobe. The same register captures the carry flag and its write enable, and the four-bit condition field and its write enable. The arithmetic shifts report a carry when a negative source drops 1-bits off its low end. When the record bit is set, the unit compares the result with zero and produces a condition field.

Top module: `dshift_unit`

## Requirements
- R1: With `in_xs_sel`=0, `in_xo`=27 shifts `in_src` left and `in_xo`=539 shifts it right, both zero-filled, by `in_amt[5:0]` when `in_amt[6]`=0.
- R2: For codes 27 and 539, `in_amt[6]`=1 gives a result of zero, whatever the low six bits hold.
- R3: With `in_xs_sel`=0 and `in_xo`=794 (arithmetic right), `in_amt[6]`=1 fills every result bit with `in_src[63]`, and the carry equals `in_src[63]`.
- R4: An arithmetic right shift by an amount from 1 to 63 fills with the sign bit. It sets the carry exactly when the source is negative and at least one 1-bit is shifted out; in every other case the carry is 0.
- R5: An amount of zero passes `in_src` through unchanged, and the carry is 0.
- R6: With `in_xs_sel`=1, the amount is {`in_imm_hi`, `in_imm_lo[4:0]`} (the high bit is bit 5). Code 413 (compared against `in_xo[8:0]`) is an arithmetic right shift by that amount and follows the carry rule of R4.
- R7: With `in_xs_sel`=1 and code 445, the result is `in_src[31:0]` sign-extended to 64 bits and then shifted left by the immediate amount. `out_ca_we` stays 0.
- R8: `out_ca_we` is 1 exactly for recognised codes 794 (register form) and 413 (immediate form).
- R9: When `in_rec`=1 on a recognised operation, `out_cr_we`=1. `out_cr0` is {LT,GT,EQ,SO}, bits 3 down to 0: LT, GT and EQ come from a signed comparison of the result with zero, and SO is a copy of `in_so`.
- R10: The outputs appear one clock after a cycle with `in_valid`=1. An unrecognised code, or a code given with the other form select, leaves `out_valid`, `out_ca_we` and `out_cr_we` at 0.
- R11: While `rst_n` is low, `out_valid`, `out_ca_we` and `out_cr_we` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Operation present this cycle |
| in_xs_sel | input | 1 | 1: immediate-amount form, compare `in_xo[8:0]`; 0: register form, compare `in_xo` |
| in_xo | input | 10 | Extended opcode field |
| in_src | input | 64 | Source operand |
| in_amt | input | 7 | Low seven bits of the amount register |
| in_imm_hi | input | 1 | High bit of the immediate amount |
| in_imm_lo | input | 5 | Low five bits of the immediate amount |
| in_rec | input | 1 | Record bit: request a condition update |
| in_so | input | 1 | Incoming summary-overflow bit |
| out_valid | output | 1 | Registered result valid |
| out_res | output | 64 | Registered result |
| out_ca_we | output | 1 | Carry write enable |
| out_ca | output | 1 | Carry value |
| out_cr_we | output | 1 | Condition field write enable |
| out_cr0 | output | 4 | {LT,GT,EQ,SO} |

## Verification
The unit holds no state beyond one output register, so any fault in decode, fill or carry logic shows on the cycle after the faulty operation is issued and cannot linger. A wrong form decode makes the valid strobe or the carry enable wrong on that cycle. A wrong fill shows only in the high bits of a negative source's result. A broken lost-bit detector shows as a carry that does not match when the dropped bits are all zero. That is why the bench pairs negative sources whose dropped bits are all zero with sources whose dropped bits include a 1.

// File: rtl/dshift_pkg.sv
package dshift_pkg;

   localparam logic [9:0] XO_SHL   = 10'd27;
   localparam logic [9:0] XO_SHR   = 10'd539;
   localparam logic [9:0] XO_SAR   = 10'd794;
   localparam logic [8:0] XSO_SARI = 9'd413;
   localparam logic [8:0] XSO_SXSL = 9'd445;

   typedef enum logic [2:0] {
      K_NONE, K_SHL, K_SHR, K_SAR, K_SARI, K_SXSL
   } op_kind_e;

   typedef struct packed {
      logic known;
      logic left;
      logic arith;
      logic imm;
      logic sxsl;
   } dshift_ctl_t;

endpackage

// File: rtl/dshift_decode.sv
module dshift_decode
   import dshift_pkg::*;
(
   input  logic        xs_sel,
   input  logic [9:0]  xo,
   output dshift_ctl_t ctl
);
   op_kind_e kind;

   always_comb begin
      kind = K_NONE;
      if (xs_sel) begin
         case (xo[8:0])
            XSO_SARI: kind = K_SARI;
            XSO_SXSL: kind = K_SXSL;
            default:  kind = K_NONE;
         endcase
      end else begin
         case (xo)
            XO_SHL:  kind = K_SHL;
            XO_SHR:  kind = K_SHR;
            XO_SAR:  kind = K_SAR;
            default: kind = K_NONE;
         endcase
      end
   end

   always_comb begin
      ctl.known = (kind != K_NONE);
      ctl.left  = (kind == K_SHL) || (kind == K_SXSL);
      ctl.arith = (kind == K_SAR) || (kind == K_SARI);
      ctl.imm   = (kind == K_SARI) || (kind == K_SXSL);
      ctl.sxsl  = (kind == K_SXSL);
   end
endmodule

// File: rtl/dshift_barrel.sv
module dshift_barrel #(
   parameter int W = 64,
   localparam int SHW = $clog2(W)
) (
   input  logic [W-1:0]   din,
   input  logic [SHW-1:0] amt,
   input  logic           left,
   input  logic           fill,
   output logic [W-1:0]   dout
);
   logic [W-1:0] rev_in;
   logic [W-1:0] rev_out;
   logic [W-1:0] st [0:SHW];

   for (genvar i = 0; i < W; i++) begin : g_rev
      assign rev_in[i]  = din[W-1-i];
      assign rev_out[i] = st[SHW][W-1-i];
   end

   assign st[0] = left ? rev_in : din;

   for (genvar k = 0; k < SHW; k++) begin : g_stage
      localparam int STEP = 1 << k;
      assign st[k+1] = amt[k] ? {{STEP{fill}}, st[k][W-1:STEP]} : st[k];
   end

   assign dout = left ? rev_out : st[SHW];
endmodule

// File: rtl/dshift_cr0.sv
module dshift_cr0 #(
   parameter int W = 64
) (
   input  logic [W-1:0] res,
   input  logic         so,
   output logic [3:0]   cr
);
   logic lt, eq, gt;

   always_comb begin
      lt = res[W-1];
      eq = (res == '0);
      gt = !lt && !eq;
      cr = {lt, gt, eq, so};
   end
endmodule

// File: rtl/dshift_unit.sv
module dshift_unit
   import dshift_pkg::*;
#(
   parameter int XLEN = 64
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            in_valid,
   input  logic            in_xs_sel,
   input  logic [9:0]      in_xo,
   input  logic [XLEN-1:0] in_src,
   input  logic [$clog2(XLEN):0] in_amt,
   input  logic            in_imm_hi,
   input  logic [$clog2(XLEN)-2:0] in_imm_lo,
   input  logic            in_rec,
   input  logic            in_so,
   output logic            out_valid,
   output logic [XLEN-1:0] out_res,
   output logic            out_ca_we,
   output logic            out_ca,
   output logic            out_cr_we,
   output logic [3:0]      out_cr0
);
   localparam int SHW  = $clog2(XLEN);
   localparam int HALF = XLEN / 2;

   if (XLEN < 8 || (1 << SHW) != XLEN) begin : g_bad_xlen
      $error("dshift_unit: XLEN must be a power of two of at least 8");
   end

   dshift_ctl_t     ctl;
   logic            ovf;
   logic [SHW-1:0]  sh;
   logic [XLEN-1:0] word_sx;
   logic [XLEN-1:0] sh_in;
   logic            fill;
   logic [XLEN-1:0] bout;
   logic            lost;
   logic [XLEN-1:0] res_c;
   logic            ca_c;
   logic [3:0]      cr_c;
   logic            take;

   dshift_decode u_dec (
      .xs_sel (in_xs_sel),
      .xo     (in_xo),
      .ctl    (ctl)
   );

   always_comb begin
      ovf     = !ctl.imm && in_amt[SHW];
      sh      = ctl.imm ? {in_imm_hi, in_imm_lo} : in_amt[SHW-1:0];
      word_sx = {{HALF{in_src[HALF-1]}}, in_src[HALF-1:0]};
      sh_in   = ctl.sxsl ? word_sx : in_src;
      fill    = ctl.arith && in_src[XLEN-1];
      lost    = |(in_src & ~({XLEN{1'b1}} << sh));
   end

   dshift_barrel #(.W(XLEN)) u_bar (
      .din  (sh_in),
      .amt  (sh),
      .left (ctl.left),
      .fill (fill),
      .dout (bout)
   );

   always_comb begin
      res_c = ovf ? {XLEN{fill}} : bout;
      ca_c  = ctl.arith && in_src[XLEN-1] && (ovf || lost);
      take  = in_valid && ctl.known;
   end

   dshift_cr0 #(.W(XLEN)) u_cr (
      .res (res_c),
      .so  (in_so),
      .cr  (cr_c)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         out_ca_we <= 1'b0;
         out_cr_we <= 1'b0;
         out_res   <= '0;
         out_ca    <= 1'b0;
         out_cr0   <= '0;
      end else begin
         out_valid <= take;
         out_ca_we <= take && ctl.arith;
         out_cr_we <= take && in_rec;
         if (take) begin
            out_res <= res_c;
            out_ca  <= ca_c;
            out_cr0 <= cr_c;
         end
      end
   end
endmodule

// File: rtl/dshift_unit_chk.sv
module dshift_unit_chk
   import dshift_pkg::*;
#(
   parameter int XLEN = 64,
   localparam int SHW = $clog2(XLEN)
) (
   input logic            clk,
   input logic            rst_n,
   input logic            in_valid,
   input logic            in_xs_sel,
   input logic [9:0]      in_xo,
   input logic [XLEN-1:0] in_src,
   input logic [SHW:0]    in_amt,
   input logic            in_so,
   input logic            out_valid,
   input logic [XLEN-1:0] out_res,
   input logic            out_ca_we,
   input logic            out_ca,
   input logic            out_cr_we,
   input logic [3:0]      out_cr0
);
   p_valid_origin_r10: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> $past(in_valid));

   p_ca_we_gated_r8: assert property (@(posedge clk) disable iff (!rst_n)
      out_ca_we |-> out_valid);

   p_cr_we_gated_r9: assert property (@(posedge clk) disable iff (!rst_n)
      out_cr_we |-> out_valid);

   p_cr_so_copy_r9: assert property (@(posedge clk) disable iff (!rst_n)
      out_cr_we |-> (out_cr0[0] == $past(in_so)));

   p_cr_onehot_r9: assert property (@(posedge clk) disable iff (!rst_n)
      out_cr_we |-> ($countones(out_cr0[3:1]) == 1));

   p_cr_eq_r9: assert property (@(posedge clk) disable iff (!rst_n)
      out_cr_we |-> (out_cr0[1] == (out_res == '0)));

   p_ovf_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
      $past(in_valid && !in_xs_sel && (in_xo == XO_SHL || in_xo == XO_SHR) && in_amt[SHW])
      |-> (out_valid && out_res == '0));

   p_ca_nonneg_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (out_ca_we && !$past(in_src[XLEN-1])) |-> !out_ca);

   p_zero_amt_r5: assert property (@(posedge clk) disable iff (!rst_n)
      $past(in_valid && !in_xs_sel && in_xo == XO_SAR && in_amt == '0)
      |-> (out_res == $past(in_src) && !out_ca));

   p_sxsl_no_ca_r7: assert property (@(posedge clk) disable iff (!rst_n)
      $past(in_valid && in_xs_sel && in_xo[8:0] == XSO_SXSL) |-> (out_valid && !out_ca_we));
endmodule

bind dshift_unit dshift_unit_chk #(.XLEN(XLEN)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .in_valid  (in_valid),
   .in_xs_sel (in_xs_sel),
   .in_xo     (in_xo),
   .in_src    (in_src),
   .in_amt    (in_amt),
   .in_so     (in_so),
   .out_valid (out_valid),
   .out_res   (out_res),
   .out_ca_we (out_ca_we),
   .out_ca    (out_ca),
   .out_cr_we (out_cr_we),
   .out_cr0   (out_cr0)
);

// File: tb/dshift_unit_test.sv
module dshift_unit_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        in_valid = 1'b0;
   logic        in_xs_sel = 1'b0;
   logic [9:0]  in_xo = '0;
   logic [63:0] in_src = '0;
   logic [6:0]  in_amt = '0;
   logic        in_imm_hi = 1'b0;
   logic [4:0]  in_imm_lo = '0;
   logic        in_rec = 1'b0;
   logic        in_so = 1'b0;
   logic        out_valid;
   logic [63:0] out_res;
   logic        out_ca_we;
   logic        out_ca;
   logic        out_cr_we;
   logic [3:0]  out_cr0;

   int checks = 0;
   int errors = 0;
   bit done = 0;

   typedef struct {
      bit          valid;
      bit [63:0]   res;
      bit          ca_we;
      bit          ca;
      bit          cr_we;
      bit [3:0]    cr;
      string       req;
   } exp_t;

   exp_t sb[$];

   always #2 clk = ~clk;

   dshift_unit uut (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_xs_sel(in_xs_sel),
      .in_xo(in_xo), .in_src(in_src), .in_amt(in_amt), .in_imm_hi(in_imm_hi),
      .in_imm_lo(in_imm_lo), .in_rec(in_rec), .in_so(in_so),
      .out_valid(out_valid), .out_res(out_res), .out_ca_we(out_ca_we),
      .out_ca(out_ca), .out_cr_we(out_cr_we), .out_cr0(out_cr0)
   );

   task automatic check(string req, string what, logic [63:0] act, logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
      end
   endtask

   function automatic exp_t model(bit xs, bit [9:0] xo, bit [63:0] s, bit [6:0] a,
                                  bit hi, bit [4:0] lo, bit rec, bit so, string req);
      exp_t e;
      int n;
      bit arith;
      e.req = req; e.valid = 0; e.res = '0; e.ca_we = 0; e.ca = 0; e.cr_we = 0; e.cr = '0;
      arith = 0;
      n = xs ? int'({hi, lo}) : int'(a[5:0]);
      if (!xs) begin
         if (xo == 10'd27) begin
            e.valid = 1; e.res = a[6] ? 64'd0 : (s << n);
         end else if (xo == 10'd539) begin
            e.valid = 1; e.res = a[6] ? 64'd0 : (s >> n);
         end else if (xo == 10'd794) begin
            e.valid = 1; arith = 1;
            if (a[6]) begin
               e.res = {64{s[63]}}; e.ca = s[63];
            end
         end
      end else begin
         if (xo[8:0] == 9'd413) begin
            e.valid = 1; arith = 1;
         end else if (xo[8:0] == 9'd445) begin
            e.valid = 1; e.res = {{32{s[31]}}, s[31:0]} << n;
         end
      end
      if (arith) begin
         e.ca_we = 1;
         if (xs || !a[6]) begin
            e.res = $signed(s) >>> n;
            e.ca = s[63] && (n != 0) && ((s & ((64'd1 << n) - 64'd1)) != 0);
         end
      end
      if (e.valid && rec) begin
         e.cr_we = 1;
         e.cr = {e.res[63], !e.res[63] && e.res != 0, e.res == 0, so};
      end
      return e;
   endfunction

   task automatic send(bit xs, bit [9:0] xo, bit [63:0] s, bit [6:0] a,
                       bit hi, bit [4:0] lo, bit rec, bit so, string req);
      @(negedge clk);
      in_valid = 1; in_xs_sel = xs; in_xo = xo; in_src = s; in_amt = a;
      in_imm_hi = hi; in_imm_lo = lo; in_rec = rec; in_so = so;
      sb.push_back(model(xs, xo, s, a, hi, lo, rec, so, req));
   endtask

   task automatic idle();
      exp_t e;
      @(negedge clk);
      in_valid = 0;
      e = model(0, 10'd0, 64'd0, 7'd0, 0, 5'd0, 0, 0, "R10");
      sb.push_back(e);
   endtask

   // monitor: compare one expected item per cycle
   initial begin
      forever begin
         @(posedge clk);
         #1;
         if (sb.size() > 0) begin
            exp_t e;
            e = sb.pop_front();
            check(e.req, "valid", 64'(out_valid), 64'(e.valid));
            check(e.req, "ca_we", 64'(out_ca_we), 64'(e.ca_we));
            check(e.req, "cr_we", 64'(out_cr_we), 64'(e.cr_we));
            if (e.valid) check(e.req, "res", out_res, e.res);
            if (e.ca_we) check(e.req, "ca", 64'(out_ca), 64'(e.ca));
            if (e.cr_we) check(e.req, "cr0", 64'(out_cr0), 64'(e.cr));
         end
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL R10 watchdog actual=hung expected=finished");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      // R11 reset state
      repeat (3) @(posedge clk);
      #1;
      check("R11", "valid in reset", 64'(out_valid), 64'd0);
      check("R11", "ca_we in reset", 64'(out_ca_we), 64'd0);
      check("R11", "cr_we in reset", 64'(out_cr_we), 64'd0);
      @(negedge clk);
      rst_n = 1;

      // R1 logical shifts
      send(0, 10'd27,  64'h0123_4567_89AB_CDEF, 7'd4,  0, 0, 0, 0, "R1");
      send(0, 10'd539, 64'h8000_0000_0000_0001, 7'd63, 0, 0, 0, 0, "R1");
      send(0, 10'd539, 64'hF000_0000_0000_0000, 7'd8,  0, 0, 0, 0, "R1");
      // R2 overflow bit
      send(0, 10'd27,  64'hFFFF_FFFF_FFFF_FFFF, 7'd69,  0, 0, 0, 0, "R2");
      send(0, 10'd539, 64'hFFFF_FFFF_FFFF_FFFF, 7'h7F,  0, 0, 1, 0, "R2");
      send(0, 10'd27,  64'h1, 7'd64, 0, 0, 0, 0, "R2");
      // R3 arithmetic overflow
      send(0, 10'd794, 64'h8000_0000_0000_0000, 7'd70, 0, 0, 0, 0, "R3");
      send(0, 10'd794, 64'h7FFF_FFFF_FFFF_FFFF, 7'd64, 0, 0, 0, 0, "R3");
      // R4 carry rule
      send(0, 10'd794, 64'hFFFF_FFFF_FFFF_FF0F, 7'd4, 0, 0, 0, 0, "R4");
      send(0, 10'd794, 64'hFFFF_FFFF_FFFF_FF00, 7'd4, 0, 0, 0, 0, "R4");
      send(0, 10'd794, 64'h7FFF_FFFF_FFFF_FFFF, 7'd4, 0, 0, 0, 0, "R4");
      send(0, 10'd794, 64'h8000_0000_0000_0001, 7'd63, 0, 0, 0, 0, "R4");
      // R5 zero amount
      send(0, 10'd794, 64'h8000_0000_0000_00FF, 7'd0, 0, 0, 0, 0, "R5");
      send(0, 10'd27,  64'hDEAD_BEEF_0000_1234, 7'd0, 0, 0, 0, 0, "R5");
      send(1, 10'd413, 64'hFFFF_FFFF_FFFF_FFFF, 7'd0, 0, 5'd0, 0, 0, "R5");
      // R6 immediate form
      send(1, 10'd413, 64'h8000_0001_0000_0000, 7'd0, 1, 5'd1, 0, 0, "R6");
      send(1, 10'd413, 64'h8000_0000_0000_0000, 7'd0, 1, 5'd1, 0, 0, "R6");
      send(1, 10'd413, 64'h4000_0000_0000_0000, 7'd0, 0, 5'd31, 0, 0, "R6");
      // R7 sign-extend word then shift left
      send(1, 10'd445, 64'h1234_5678_8000_0001, 7'd0, 1, 5'd3, 0, 0, "R7");
      send(1, 10'd445, 64'hFFFF_FFFF_7000_0001, 7'd0, 0, 5'd4, 0, 0, "R7");
      send(1, 10'd445, 64'hAAAA_AAAA_C000_0003, 7'd0, 0, 5'd0, 0, 0, "R7");
      // R9 condition field
      send(0, 10'd27,  64'h0000_0000_0000_0001, 7'd63, 0, 0, 1, 1, "R9");
      send(0, 10'd539, 64'h0000_0000_0000_0100, 7'd4,  0, 0, 1, 0, "R9");
      send(0, 10'd539, 64'h0000_0000_0000_0001, 7'd1,  0, 0, 1, 1, "R9");
      send(1, 10'd445, 64'h0,                   7'd0,  0, 5'd2, 1, 0, "R9");
      // R8 / R10 unrecognised or wrong-form codes
      send(0, 10'd100, 64'h1, 7'd1, 0, 0, 1, 0, "R10");
      send(1, 10'd27,  64'h1, 7'd1, 0, 0, 1, 0, "R10");
      send(0, 10'd413, 64'h8000_0000_0000_0001, 7'd1, 0, 0, 1, 0, "R8");
      send(1, 10'd794, 64'h8000_0000_0000_0001, 7'd1, 0, 0, 1, 0, "R8");
      idle();
      send(0, 10'd794, 64'h8000_0000_0000_0003, 7'd1, 0, 0, 1, 1, "R8");
      idle();
      idle();

      // mixed traffic
      for (int i = 0; i < 300; i++) begin
         bit [9:0] codes [6];
         int pick;
         codes[0] = 10'd27; codes[1] = 10'd539; codes[2] = 10'd794;
         codes[3] = 10'd413; codes[4] = 10'd445; codes[5] = 10'd3;
         pick = int'($urandom_range(0, 5));
         if ($urandom_range(0, 7) == 0) idle();
         send(pick >= 3, codes[pick], {$urandom, $urandom}, 7'($urandom),
              1'($urandom), 5'($urandom), 1'($urandom), 1'($urandom), "R4");
      end
      idle();
      idle();
      repeat (3) @(posedge clk);
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule